// File: doc/BRIEF.md
# DS3/E3 Receive Information Register

This block gathers receive-side line and framing indications of a DS3/E3 framer into one 8-bit information register for a host to read. Four of its bits are sticky: each one goes to 1 when its event is seen, and only a host write of 1 to that bit position clears it. Three bits are real-time copies of receive conditions. The remaining bit always reads 0. No bit drives an interrupt.

Zero-suppression codeword detections, F/FAS errors and M-bit errors arrive from the line decoder and framer as single-cycle pulses. The excessive-zeros indication comes from a run-length detector inside the block, which watches the recovered bit stream. The run threshold depends on the line mode: three zeros in DS3 and four zeros in E3. Binary (non-coded) line mode turns off both the zero detector and the codeword latch. E3 mode holds the M-bit latch at 0.

Top module: `rx_status_reg`

## Requirements
- R1: After a synchronous active-low reset, every bit of `stat_q` is 0.
- R2: Bits 0 (codeword), 1 (F/FAS error) and 2 (M-bit error) read 1 from the cycle after their event pulse. They then stay 1 until the host clears them.
- R3: A host write (`host_wr_en`=1) with a 1 at bit position 0..3 of `host_wr_data` clears that latched bit on the next cycle. A 0 at a bit position leaves that bit unchanged.
- R4: If a bit's set event and the host clear for that same bit arrive in the same cycle, the bit reads 1 afterwards.
- R5: In DS3 mode (`mode_e3`=0), bit 3 sets in the cycle after the third consecutive valid 0 on `rx_data`. A valid 1 restarts the count. Cycles with `rx_valid`=0 neither count nor break the run.
- R6: In E3 mode (`mode_e3`=1), three consecutive valid zeros leave bit 3 clear. The fourth one sets it.
- R7: A zero run raises the excessive-zeros event only once. If bit 3 is cleared while the run is still going, it stays clear until a valid 1 arrives and a new run reaches the threshold.
- R8: While `mode_bin`=1, neither codeword pulses nor zero runs set bits 0 or 3. The zero-run count also restarts from 0.
- R9: While `mode_e3`=1, bit 2 reads 0 from the next cycle on. M-bit pulses do not set it.
- R10: In E3 mode, bit 5 takes the value of `nat_bit` on each cycle with `frame_start`=1, and holds its value on every other cycle. In DS3 mode, `frame_start` has no effect on bit 5.
- R11: Bits 6 and 7 show `app_id_cbit` and `unframed_ones` one cycle later. Host writes do not change bits 4 to 7, and bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_e3 | input | 1 | 1 = E3 line mode, 0 = DS3 line mode |
| mode_bin | input | 1 | 1 = binary line mode (no zero coding) |
| rx_valid | input | 1 | Qualifies `rx_data` in this cycle |
| rx_data | input | 1 | Recovered received bit |
| zcw_evt | input | 1 | Zero-suppression codeword detected pulse |
| fas_err_evt | input | 1 | F-bit or FAS error pulse |
| mbit_err_evt | input | 1 | M-bit error pulse |
| nat_bit | input | 1 | Decoded E3 national bit |
| frame_start | input | 1 | E3 frame-start strobe |
| app_id_cbit | input | 1 | DS3 application-ID status from the framer |
| unframed_ones | input | 1 | Unframed all-ones detected |
| host_wr_en | input | 1 | Host write strobe for the register |
| host_wr_data | input | 8 | Host write data, 1 = clear that latched bit |
| stat_q | output | 8 | Information register read value |

## Verification
The zero-run detector is driven with the following patterns, each in both modes:
- Runs one zero short of the threshold and runs exactly at it. These separate the DS3 threshold from the E3 threshold.
- Runs that are broken by a 1. These show the count restarts.
- Runs that contain cycles with `rx_valid`=0. These show that idle cycles are not counted as zeros.
- Runs that continue after the host clears bit 3. These tell a detector that fires once per run from one that fires on every zero past the threshold.

For the latched bits, the bench writes masks that mix 0s and 1s, and writes that coincide with a set event. These show that clearing is per bit and that a set wins a same-cycle conflict. Switching between binary mode and E3 mode shows each gate acting on exactly the bit it guards.

// File: rtl/rxs_pkg.sv
// Package rxs_pkg
// Holds the bit positions and widths of the receive information register.
// Assumes the host reads the register as one 8-bit word. The positions
// matter because host software decodes them.
package rxs_pkg;
    localparam int STAT_W     = 8;
    localparam int LATCH_N    = 4;
    localparam int B_ZCW      = 0;
    localparam int B_FAS      = 1;
    localparam int B_MBIT     = 2;
    localparam int B_EXZ      = 3;
    localparam int B_RSVD     = 4;
    localparam int B_NAT      = 5;
    localparam int B_APPID    = 6;
    localparam int B_UA1      = 7;
endpackage

// File: rtl/rxs_zero_run.sv
// Module rxs_zero_run
// Counts consecutive valid zeros on the recovered stream. It pulses exz_evt
// in the cycle where the run reaches the threshold for the current mode.
// The count saturates, so one run gives at most one pulse.
// Assumes both thresholds are at least 1. Binary mode holds the count at 0.
module rxs_zero_run #(
    parameter int DS3_RUN = 3,
    parameter int E3_RUN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_e3,
    input  logic mode_bin,
    input  logic rx_valid,
    input  logic rx_data,
    output logic exz_evt
);
    localparam int MAX_RUN = (DS3_RUN > E3_RUN) ? DS3_RUN : E3_RUN;
    localparam int CNT_W   = $clog2(MAX_RUN + 1);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] thr_m1;

    // Select the count value that one more zero turns into an event.
    always_comb begin
        thr_m1 = mode_e3 ? CNT_W'(E3_RUN - 1) : CNT_W'(DS3_RUN - 1);
    end

    // Track the length of the current run of valid zeros, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (mode_bin) begin
            run_cnt <= '0;
        end else if (rx_valid) begin
            if (rx_data) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_W'(MAX_RUN)) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Flag the zero that brings the run up to the threshold.
    always_comb begin
        exz_evt = rx_valid && !mode_bin && !rx_data && (run_cnt == thr_m1);
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exz_evt |=> (!exz_evt || !$stable(mode_e3)));

    // R5
    run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_data) |=> (run_cnt == '0));

    // R8
    bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bin |=> (run_cnt == '0));
endmodule

// File: rtl/rxs_w1c_bit.sv
// Module rxs_w1c_bit
// One sticky status bit. It is set by set_i and cleared by clr_i. When both
// are high in the same cycle, the set wins. Assumes set_i is a single-cycle
// pulse, already gated for mode by the caller.
module rxs_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    // Hold, set or clear the sticky bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q);

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/rxs_rt_fields.sv
// Module rxs_rt_fields
// Registers the real-time fields of the information register.
// - The national bit is sampled on E3 frame starts and held between them.
// - The application-ID status and the all-ones flag are copied every cycle.
// Assumes frame_start is one cycle wide and lines up with a valid nat_bit.
module rxs_rt_fields (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_e3,
    input  logic nat_bit,
    input  logic frame_start,
    input  logic app_id_cbit,
    input  logic unframed_ones,
    output logic nat_q,
    output logic appid_q,
    output logic ua1_q
);
    // Load the national bit at each E3 frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nat_q <= 1'b0;
        end else if (mode_e3 && frame_start) begin
            nat_q <= nat_bit;
        end
    end

    // Copy the continuous receive conditions every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            appid_q <= 1'b0;
            ua1_q   <= 1'b0;
        end else begin
            appid_q <= app_id_cbit;
            ua1_q   <= unframed_ones;
        end
    end

    // R10
    nat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_e3 && frame_start) |=> $stable(nat_q));

    // R11
    ua1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unframed_ones |=> ua1_q);
endmodule

// File: rtl/rx_status_reg.sv
// Module rx_status_reg
// The DS3/E3 receive information register.
// - Bits 0..3 are sticky and cleared by a host write of 1.
// - Bits 5..7 are real-time.
// - Bit 4 reads 0.
// Mode gates:
// - Binary mode blocks the codeword and excessive-zeros bits.
// - E3 mode holds the M-bit error bit at 0.
// Assumes event inputs are single-cycle pulses in the clk domain. There is
// no interrupt output.
module rx_status_reg
    import rxs_pkg::*;
#(
    parameter int DS3_RUN = 3,
    parameter int E3_RUN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_e3,
    input  logic              mode_bin,
    input  logic              rx_valid,
    input  logic              rx_data,
    input  logic              zcw_evt,
    input  logic              fas_err_evt,
    input  logic              mbit_err_evt,
    input  logic              nat_bit,
    input  logic              frame_start,
    input  logic              app_id_cbit,
    input  logic              unframed_ones,
    input  logic              host_wr_en,
    input  logic [STAT_W-1:0] host_wr_data,
    output logic [STAT_W-1:0] stat_q
);
    logic                exz_evt;
    logic [LATCH_N-1:0]  lat_set;
    logic [LATCH_N-1:0]  lat_clr;
    logic [LATCH_N-1:0]  lat_q;
    logic                nat_q;
    logic                appid_q;
    logic                ua1_q;

    rxs_zero_run #(
        .DS3_RUN (DS3_RUN),
        .E3_RUN  (E3_RUN)
    ) u_zrun (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_e3  (mode_e3),
        .mode_bin (mode_bin),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .exz_evt  (exz_evt)
    );

    // Apply the mode gates to the event pulses.
    always_comb begin
        lat_set         = '0;
        lat_set[B_ZCW]  = zcw_evt && !mode_bin;
        lat_set[B_FAS]  = fas_err_evt;
        lat_set[B_MBIT] = mbit_err_evt && !mode_e3;
        lat_set[B_EXZ]  = exz_evt;
    end

    // Form the per-bit clears. E3 mode also forces the M-bit bit to 0.
    always_comb begin
        lat_clr         = {LATCH_N{host_wr_en}} & host_wr_data[LATCH_N-1:0];
        lat_clr[B_MBIT] = lat_clr[B_MBIT] || mode_e3;
    end

    for (genvar gi = 0; gi < LATCH_N; gi++) begin : g_lat
        rxs_w1c_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (lat_set[gi]),
            .clr_i (lat_clr[gi]),
            .q     (lat_q[gi])
        );
    end

    rxs_rt_fields u_rt (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_e3       (mode_e3),
        .nat_bit       (nat_bit),
        .frame_start   (frame_start),
        .app_id_cbit   (app_id_cbit),
        .unframed_ones (unframed_ones),
        .nat_q         (nat_q),
        .appid_q       (appid_q),
        .ua1_q         (ua1_q)
    );

    // Assemble the host-visible word.
    always_comb begin
        stat_q                  = '0;
        stat_q[LATCH_N-1:0]     = lat_q;
        stat_q[B_RSVD]          = 1'b0;
        stat_q[B_NAT]           = nat_q;
        stat_q[B_APPID]         = appid_q;
        stat_q[B_UA1]           = ua1_q;
    end

    // R8
    bin_zcw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bin && !stat_q[B_ZCW]) |=> !stat_q[B_ZCW]);

    // R9
    e3_mbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_e3 |=> !stat_q[B_MBIT]);

    // R11
    rt_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && (|host_wr_data[STAT_W-1:LATCH_N]) && !(mode_e3 && frame_start))
            |=> $stable(stat_q[B_NAT]));
endmodule

// File: tb/rx_status_reg_bench.sv
module rx_status_reg_bench;
    typedef struct packed {
        logic       e3;
        logic       bin;
        logic       vld;
        logic       dat;
        logic       zcw;
        logic       fas;
        logic       mbit;
        logic       we;
        logic [7:0] wd;
        logic       nat;
        logic       fs;
        logic       aid;
        logic       ua1;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 49;
    // fields: e3 bin vld dat zcw fas mbit we wd nat fs aid ua1 exp req
    localparam vec_t VT [NV] = '{
        '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,1},  // 0  R1 idle
        '{0,0,0,0,1,0,0,0,8'h00,0,0,0,0,8'h01,2},  // 1  R2 codeword
        '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h01,2},  // 2  R2 holds
        '{0,0,0,0,0,0,0,1,8'hFE,0,0,0,0,8'h01,3},  // 3  R3 zero leaves bit
        '{0,0,0,0,0,0,0,1,8'h01,0,0,0,0,8'h00,3},  // 4  R3 clear
        '{0,0,0,0,0,1,0,0,8'h00,0,0,0,0,8'h02,2},  // 5  R2 fas
        '{0,0,0,0,0,0,1,0,8'h00,0,0,0,0,8'h06,2},  // 6  R2 mbit
        '{0,0,0,0,0,1,0,1,8'h06,0,0,0,0,8'h02,4},  // 7  R4 set wins
        '{0,0,0,0,0,0,0,1,8'h02,0,0,0,0,8'h00,3},  // 8  R3
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 9  R5 z1
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 10 R5 z2
        '{0,0,1,1,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 11 R5 one resets
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 12 R5 z1
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 13 R5 z2
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h08,5},  // 14 R5 z3 fires
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h08,7},  // 15 R7 z4
        '{0,0,1,0,0,0,0,1,8'h08,0,0,0,0,8'h00,7},  // 16 R7 clear mid-run
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,7},  // 17 R7 no refire
        '{0,0,1,1,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 18 R5 one
        '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 19 R5 invalid
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 20 R5 z1
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 21 R5 z2
        '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,5},  // 22 R5 gap
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h08,5},  // 23 R5 z3 across gap
        '{0,0,1,1,0,0,0,1,8'h08,0,0,0,0,8'h00,3},  // 24 R3
        '{1,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,6},  // 25 R6 z1
        '{1,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,6},  // 26 R6 z2
        '{1,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,6},  // 27 R6 z3 quiet
        '{1,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h08,6},  // 28 R6 z4 fires
        '{1,0,0,0,0,0,1,1,8'h08,0,0,0,0,8'h00,9},  // 29 R9 mbit ignored
        '{1,0,0,0,0,0,1,0,8'h00,0,0,0,0,8'h00,9},  // 30 R9
        '{1,0,0,0,0,0,0,0,8'h00,1,1,0,0,8'h20,10}, // 31 R10 load 1
        '{1,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h20,10}, // 32 R10 hold
        '{1,0,0,0,0,0,0,0,8'h00,0,1,0,0,8'h00,10}, // 33 R10 load 0
        '{0,0,0,0,0,0,0,0,8'h00,1,1,0,0,8'h00,10}, // 34 R10 DS3 ignores
        '{0,0,0,0,0,0,1,0,8'h00,0,0,0,0,8'h04,2},  // 35 R2 mbit
        '{1,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,9},  // 36 R9 forced 0
        '{0,0,0,0,0,0,0,0,8'h00,0,0,1,1,8'hC0,11}, // 37 R11 follow
        '{0,0,0,0,0,0,0,1,8'hFF,0,0,0,1,8'h80,11}, // 38 R11 write ignored
        '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,11}, // 39 R11
        '{0,1,0,0,1,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 40 R8 codeword blocked
        '{0,1,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 41 R8
        '{0,1,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 42 R8
        '{0,1,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 43 R8 no exz
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 44 R8 count restarted
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h00,8},  // 45 R8
        '{0,0,1,0,0,0,0,0,8'h00,0,0,0,0,8'h08,5},  // 46 R5
        '{0,0,0,0,1,1,0,0,8'h00,0,0,0,0,8'h0B,2},  // 47 R2 two events
        '{0,0,0,0,0,0,0,1,8'h0B,0,0,0,0,8'h00,3}   // 48 R3 multi clear
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_e3, mode_bin, rx_valid, rx_data;
    logic       zcw_evt, fas_err_evt, mbit_err_evt;
    logic       nat_bit, frame_start, app_id_cbit, unframed_ones;
    logic       host_wr_en;
    logic [7:0] host_wr_data;
    logic [7:0] stat_q;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    rx_status_reg u_rx_status_reg (
        .clk (clk), .rst_n (rst_n), .mode_e3 (mode_e3), .mode_bin (mode_bin),
        .rx_valid (rx_valid), .rx_data (rx_data), .zcw_evt (zcw_evt),
        .fas_err_evt (fas_err_evt), .mbit_err_evt (mbit_err_evt),
        .nat_bit (nat_bit), .frame_start (frame_start),
        .app_id_cbit (app_id_cbit), .unframed_ones (unframed_ones),
        .host_wr_en (host_wr_en), .host_wr_data (host_wr_data),
        .stat_q (stat_q)
    );

    task automatic drive(input vec_t v);
        mode_e3 = v.e3;  mode_bin = v.bin; rx_valid = v.vld; rx_data = v.dat;
        zcw_evt = v.zcw; fas_err_evt = v.fas; mbit_err_evt = v.mbit;
        host_wr_en = v.we; host_wr_data = v.wd; nat_bit = v.nat;
        frame_start = v.fs; app_id_cbit = v.aid; unframed_ones = v.ua1;
    endtask

    task automatic check(input logic [7:0] exp, input int req, input int idx);
        n_chk++;
        if (stat_q !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: stat_q=%02h expected %02h", req, idx, stat_q, exp);
        end
    endtask

    localparam vec_t IDLE = '{0,0,0,0,0,0,0,0,8'h00,0,0,0,0,8'h00,0};

    initial begin
        rst_n = 1'b0;
        drive(IDLE);
        repeat (3) @(negedge clk);
        check(8'h00, 1, -1);                 // R1 while in reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            @(negedge clk);
            check(VT[i].exp, int'(VT[i].req), i);
        end
        // R4 directed: codeword set with a clear of bit 0 in the same cycle
        drive('{0,0,0,0,1,0,0,1,8'h01,0,0,0,0,8'h00,0});
        @(negedge clk);
        check(8'h01, 4, 100);
        // R2 directed: F/FAS error still latches in E3 mode
        drive('{1,0,0,0,0,1,0,0,8'h00,0,0,1,1,8'h00,0});
        @(negedge clk);
        check(8'hC3, 2, 101);
        // R1 directed: reset mid-operation clears every bit
        drive(IDLE);
        rst_n = 1'b0;
        @(negedge clk);
        check(8'h00, 1, 102);
        rst_n = 1'b1;
        @(negedge clk);
        check(8'h00, 1, 103);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule